// File: doc/BRIEF.md
# Zero-Count Check Code Link (Encoder and Checker)

This block protects a K-bit data word crossing an unreliable path against unidirectional corruption, meaning any number of bits that all fail the same way: every flipped bit goes 1 to 0, or every flipped bit goes 0 to 1. The sending half keeps the data bits unchanged and places a check field below them. The check field holds the count of zero bits in the data. The receiving half takes a codeword, counts the zeros in its data part again, and compares that count with the check field it received. It then reports a single good/bad verdict.

The two halves share one clock but run independently. Each half has a one-cycle input strobe and registers its result. The matching output strobe follows one cycle later. Between strobes, the registered outputs keep their last value. The check field is `$clog2(K+1)` bits wide, which is enough to hold any count from 0 to K.

Top module: `berger_link`

## Requirements
- R1: The encoder codeword is {data, check}: bits [CW-1:CHK_W] carry the data word unchanged and bits [CHK_W-1:0] carry the check field, with CHK_W = $clog2(K+1) and CW = K + CHK_W.
- R2: The encoder check field equals the number of 0 bits in the data word. An all-ones word gives 0 and an all-zeros word gives K.
- R3: `enc_strobe_o` is high exactly in the cycle after a cycle with `enc_strobe_i` high, and is low otherwise.
- R4: While no encoder strobe is accepted, `enc_word_o` keeps its previous value.
- R5: The checker sets `chk_ok_o` to 1 when the received check field equals the number of zeros in the received data field, and sets it to 0 otherwise.
- R6: `chk_strobe_o` is high exactly in the cycle after a cycle with `chk_strobe_i` high.
- R7: Every valid codeword that suffers a unidirectional error of one or more bits, anywhere in the data or check field, is reported with `chk_ok_o` = 0.
- R8: A received check field larger than K is always reported invalid.
- R9: While `rst` is high at a clock edge, both strobes and all registered outputs are cleared to 0.
- R10: `chk_info_o` carries the received data field unchanged, registered alongside the verdict.
- R11: While no checker strobe is accepted, `chk_ok_o` and `chk_info_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_strobe_i | input | 1 | Encoder input strobe |
| enc_info_i | input | K | Data word to encode |
| enc_strobe_o | output | 1 | Encoder result strobe |
| enc_word_o | output | K+CHK_W | Registered codeword {data, check} |
| chk_strobe_i | input | 1 | Checker input strobe |
| chk_word_i | input | K+CHK_W | Received codeword |
| chk_strobe_o | output | 1 | Checker result strobe |
| chk_ok_o | output | 1 | 1 when the codeword is consistent |
| chk_info_o | output | K | Registered received data field |

## Verification
The case that is hardest to reach from the ports is a multi-bit unidirectional error that hits the data field and the check field together. In that case, the shift in the zero count and the drop or rise in the check value have to be shown never to cancel out. The bench builds valid codewords and picks one direction. It then flips a random subset of the bits that hold the source value across the whole codeword, always flipping at least one bit. The bench also adds directed all-ones and all-zeros words, and check fields pushed above K.

// File: rtl/berger_pkg.sv
package berger_pkg;
  function automatic int unsigned chk_width(input int unsigned k);
    return $clog2(k + 1);
  endfunction
endpackage

// File: rtl/berger_zero_count.sv
module berger_zero_count #(
  parameter int unsigned K     = 16,
  parameter int unsigned CHK_W = berger_pkg::chk_width(K)
) (
  input  logic [K-1:0]     bits_i,
  output logic [CHK_W-1:0] zeros_o
);
  logic [CHK_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < K; i++) begin
      acc = acc + CHK_W'(!bits_i[i]);
    end
  end

  assign zeros_o = acc;

  always_comb begin
    if (bits_i == '1) assert (zeros_o == '0) else $error("p_ones_zero_r2");
  end
endmodule

// File: rtl/berger_encoder.sv
module berger_encoder #(
  parameter int unsigned K     = 16,
  parameter int unsigned CHK_W = berger_pkg::chk_width(K),
  localparam int unsigned CW   = K + CHK_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe_i,
  input  logic [K-1:0]  info_i,
  output logic          strobe_o,
  output logic [CW-1:0] word_o
);
  logic [CHK_W-1:0] zeros;

  berger_zero_count #(.K(K), .CHK_W(CHK_W)) u_cnt (
    .bits_i  (info_i),
    .zeros_o (zeros)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_o <= 1'b0;
      word_o   <= '0;
    end else begin
      strobe_o <= strobe_i;
      if (strobe_i) word_o <= {info_i, zeros};
    end
  end

  p_strobe_lat_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (strobe_o == $past(strobe_i)));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strobe_i)) |-> $stable(word_o));
  p_chk_range_r2: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> (word_o[CHK_W-1:0] <= CHK_W'(K)));
  p_data_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strobe_i)) |-> (word_o[CW-1:CHK_W] == $past(info_i)));
endmodule

// File: rtl/berger_checker.sv
module berger_checker #(
  parameter int unsigned K     = 16,
  parameter int unsigned CHK_W = berger_pkg::chk_width(K),
  localparam int unsigned CW   = K + CHK_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe_i,
  input  logic [CW-1:0] word_i,
  output logic          strobe_o,
  output logic          ok_o,
  output logic [K-1:0]  info_o
);
  logic [K-1:0]     rx_info;
  logic [CHK_W-1:0] rx_chk;
  logic [CHK_W-1:0] recount;
  logic [CHK_W-1:0] chk_q;

  assign rx_info = word_i[CW-1:CHK_W];
  assign rx_chk  = word_i[CHK_W-1:0];

  berger_zero_count #(.K(K), .CHK_W(CHK_W)) u_cnt (
    .bits_i  (rx_info),
    .zeros_o (recount)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_o <= 1'b0;
      ok_o     <= 1'b0;
      info_o   <= '0;
      chk_q    <= '0;
    end else begin
      strobe_o <= strobe_i;
      if (strobe_i) begin
        ok_o   <= (rx_chk == recount);
        info_o <= rx_info;
        chk_q  <= rx_chk;
      end
    end
  end

  p_strobe_lat_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (strobe_o == $past(strobe_i)));
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strobe_i)) |-> ($stable(ok_o) && $stable(info_o)));
  p_range_r8: assert property (@(posedge clk) disable iff (rst)
    ok_o |-> (chk_q <= CHK_W'(K)));
  p_ones_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe_o && info_o == '1) |-> (ok_o == (chk_q == '0)));
endmodule

// File: rtl/berger_link.sv
module berger_link #(
  parameter int unsigned K     = 16,
  localparam int unsigned CHK_W = berger_pkg::chk_width(K),
  localparam int unsigned CW    = K + CHK_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enc_strobe_i,
  input  logic [K-1:0]  enc_info_i,
  output logic          enc_strobe_o,
  output logic [CW-1:0] enc_word_o,
  input  logic          chk_strobe_i,
  input  logic [CW-1:0] chk_word_i,
  output logic          chk_strobe_o,
  output logic          chk_ok_o,
  output logic [K-1:0]  chk_info_o
);
  berger_encoder #(.K(K), .CHK_W(CHK_W)) u_enc (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (enc_strobe_i),
    .info_i   (enc_info_i),
    .strobe_o (enc_strobe_o),
    .word_o   (enc_word_o)
  );

  berger_checker #(.K(K), .CHK_W(CHK_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (chk_strobe_i),
    .word_i   (chk_word_i),
    .strobe_o (chk_strobe_o),
    .ok_o     (chk_ok_o),
    .info_o   (chk_info_o)
  );

  p_reset_r9: assert property (@(posedge clk)
    $past(rst) |-> (!enc_strobe_o && !chk_strobe_o && !chk_ok_o));
endmodule

// File: tb/berger_link_bench.sv
module berger_link_bench;
  localparam int K     = 16;
  localparam int CHK_W = $clog2(K + 1);
  localparam int CW    = K + CHK_W;
  localparam time CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enc_strobe_i = 1'b0;
  logic [K-1:0]  enc_info_i = '0;
  logic          enc_strobe_o;
  logic [CW-1:0] enc_word_o;
  logic          chk_strobe_i = 1'b0;
  logic [CW-1:0] chk_word_i = '0;
  logic          chk_strobe_o;
  logic          chk_ok_o;
  logic [K-1:0]  chk_info_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  berger_link #(.K(K)) u_berger_link (.*);

  function automatic int zeros(input logic [K-1:0] d);
    int z = 0;
    for (int i = 0; i < K; i++) if (!d[i]) z++;
    return z;
  endfunction

  function automatic logic [CW-1:0] encode(input logic [K-1:0] d);
    return {d, CHK_W'(zeros(d))};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic enc_send(input logic [K-1:0] d);
    logic [CW-1:0] prev;
    @(negedge clk);
    prev = enc_word_o;
    enc_strobe_i = 1'b1; enc_info_i = d;
    @(negedge clk);
    enc_strobe_i = 1'b0; enc_info_i = ~d;
    check(enc_strobe_o == 1'b1, "R3", 64'(enc_strobe_o), 64'd1);
    check(enc_word_o[CW-1:CHK_W] == d, "R1", 64'(enc_word_o[CW-1:CHK_W]), 64'(d));
    check(enc_word_o[CHK_W-1:0] == CHK_W'(zeros(d)), "R2", 64'(enc_word_o[CHK_W-1:0]), 64'(zeros(d)));
    prev = enc_word_o;
    @(negedge clk);
    check(enc_strobe_o == 1'b0, "R3", 64'(enc_strobe_o), 64'd0);
    check(enc_word_o == prev, "R4", 64'(enc_word_o), 64'(prev));
  endtask

  task automatic chk_send(input logic [CW-1:0] w, input bit exp_ok, input string req);
    logic pok; logic [K-1:0] pinfo;
    @(negedge clk);
    chk_strobe_i = 1'b1; chk_word_i = w;
    @(negedge clk);
    chk_strobe_i = 1'b0; chk_word_i = ~w;
    check(chk_strobe_o == 1'b1, "R6", 64'(chk_strobe_o), 64'd1);
    check(chk_ok_o == exp_ok, req, 64'(chk_ok_o), 64'(exp_ok));
    check(chk_info_o == w[CW-1:CHK_W], "R10", 64'(chk_info_o), 64'(w[CW-1:CHK_W]));
    pok = chk_ok_o; pinfo = chk_info_o;
    @(negedge clk);
    check(chk_strobe_o == 1'b0, "R6", 64'(chk_strobe_o), 64'd0);
    check(chk_ok_o == pok && chk_info_o == pinfo, "R11", 64'(chk_ok_o), 64'(pok));
  endtask

  function automatic logic [CW-1:0] uni_err(input logic [CW-1:0] w, input bit up);
    logic [CW-1:0] r = w;
    int first = -1;
    bit any = 0;
    for (int i = 0; i < CW; i++) begin
      if (w[i] == !up) begin
        if (first < 0) first = i;
        if ($urandom_range(1, 0) == 1) begin r[i] = up; any = 1; end
      end
    end
    if (!any && first >= 0) r[first] = up;
    return r;
  endfunction

  initial begin
    void'($urandom(32'h5eed_0b1e));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(enc_strobe_o == 0 && chk_strobe_o == 0, "R9", 64'(enc_strobe_o), 64'd0);
    check(enc_word_o == '0 && chk_ok_o == 0 && chk_info_o == '0, "R9", 64'(enc_word_o), 64'd0);
    rst = 1'b0;

    enc_send('1);
    enc_send('0);
    enc_send(K'(1));
    for (int n = 0; n < 200; n++) enc_send(K'($urandom));

    chk_send(encode('1), 1'b1, "R5");
    chk_send(encode('0), 1'b1, "R5");
    chk_send({K'('1), CHK_W'(1)}, 1'b0, "R5");
    chk_send({K'('0), CHK_W'((1 << CHK_W) - 1)}, 1'b0, "R8");
    for (int n = 0; n < 50; n++) begin
      logic [K-1:0] d = K'($urandom);
      int big = K + 1 + int'($urandom_range((1 << CHK_W) - K - 2, 0));
      chk_send({d, CHK_W'(big)}, 1'b0, "R8");
    end
    for (int n = 0; n < 200; n++) begin
      logic [CW-1:0] w = CW'({$urandom, $urandom});
      chk_send(w, w[CHK_W-1:0] == CHK_W'(zeros(w[CW-1:CHK_W])), "R5");
    end
    for (int n = 0; n < 400; n++) begin
      logic [K-1:0] d = (n == 0) ? '1 : (n == 1) ? '0 : K'($urandom);
      logic [CW-1:0] good = encode(d);
      chk_send(good, 1'b1, "R5");
      chk_send(uni_err(good, n[0]), 1'b0, "R7");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule